// File: doc/BRIEF.md
# Segmented Word Stack Unit

This unit keeps a downward-growing stack of 16-bit words in a byte-wide memory that uses segmented addressing. It holds a 16-bit segment register and a 16-bit stack pointer. The physical address is the segment shifted left by four bits plus the pointer offset, taken to 20 bits. A push or pop request starts a fixed sequence of two byte accesses on the memory port, low byte first, followed by a one-cycle completion pulse. The pointer is updated at the end of the second access.

The unit always shows the current top-of-stack physical address. Software or a controller can load either register through a small write port while the unit is idle. The memory is read combinationally: read data for the address driven in a cycle must be valid in that cycle. Writes are taken at the clock edge that ends the cycle in which they are driven.

Top module: `seg_stack_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the pointer takes RST_SP and the segment takes RST_SS. After that edge, busy, done and mem_en are 0.
- R2: tos_addr always equals (segment × 16 + pointer) mod 2^20. For example, segment 0105h with pointer 0008h gives 01058h.
- R3: In the first cycle after a push is accepted, mem_we=1 and the low data byte is driven to phys(segment, pointer−2). In the second cycle, mem_we=1 and the high byte is driven to phys(segment, pointer−1). Pushing 1234h with pointer 0008h in segment 0105h writes 34h at 01056h and 12h at 01057h.
- R4: When a push completes, the pointer has decreased by 2 (mod 2^16).
- R5: A pop reads the low byte from phys(segment, pointer) and then the high byte from phys(segment, pointer+1), with mem_we=0 in both cycles. pop_data = {high, low} is valid while done=1, and the pointer has increased by 2 by then.
- R6: A request is accepted at a clock edge in idle. The two access cycles follow, and done is high for exactly the third cycle. busy is high for all three of those cycles.
- R7: push_req and pop_req are ignored while busy=1. Each accepted request produces exactly one two-access sequence.
- R8: If push_req and pop_req are both high in idle, the push is performed.
- R9: reg_we loads the pointer when reg_sel=0 and the segment when reg_sel=1. The load happens only in idle, and a request in that same cycle is ignored. reg_we has no effect while busy=1.
- R10: Offsets wrap mod 2^16 inside the segment, and physical addresses wrap mod 2^20. Examples: a push at pointer 0000h writes offsets FFFEh and FFFFh. A pop at pointer FFFFh in segment 0105h reads 1104Fh and then 01050h. Segment FFFFh with offset 0010h maps to 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop a word |
| push_data | input | 16 | Word to be pushed |
| reg_we | input | 1 | Register load strobe |
| reg_sel | input | 1 | 0 selects the pointer, 1 selects the segment |
| reg_wdata | input | 16 | Register load value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Popped word, valid with done after a pop |
| sp_out | output | 16 | Current stack pointer |
| ss_out | output | 16 | Current stack segment |
| tos_addr | output | 20 | Physical address of the top of stack |
| mem_en | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, combinational |

## Verification
The hardest case to reach is a word whose two bytes land on opposite ends of a segment. This happens with pointer FFFFh, where the high byte wraps to offset 0000h, and with a segment near the top of the 20-bit space, where the physical address wraps to zero. The stimulus loads these pointer and segment values through the write port. It pushes words at those points and pops them back, so both the driven addresses and the reassembled word are checked. Separate directed runs hold requests and register loads high across the busy window to show they are dropped.

// File: rtl/seg_stack_pkg.sv
// Shared types for the segmented word stack unit.
// Assumes: one byte access per cycle on the memory port.
package seg_stack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_DONE
    } stk_state_t;
endpackage

// File: rtl/stk_addr_gen.sv
// Forms a physical address from a segment and an offset.
// Assumes: the segment is shifted by SEG_SHIFT bits, and the result wraps
// at OFF_W+SEG_SHIFT bits.
module stk_addr_gen #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = OFF_W + SEG_SHIFT
) (
    input  logic [OFF_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] off_ext;

    // Shifted segment base plus zero-extended offset, modulo 2^ADDR_W.
    always_comb begin
        seg_base = {seg, {SEG_SHIFT{1'b0}}};
        off_ext  = {{SEG_SHIFT{1'b0}}, off};
        phys     = seg_base + off_ext;
    end
endmodule

// File: rtl/stk_ptr_regs.sv
// Holds the stack pointer and the segment register.
// Assumes: wr_ok already means the unit is idle; a step and a load never
// happen together.
module stk_ptr_regs #(
    parameter int               OFF_W  = 16,
    parameter logic [OFF_W-1:0] RST_SP = '0,
    parameter logic [OFF_W-1:0] RST_SS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             wr_sel,
    input  logic [OFF_W-1:0] wr_data,
    input  logic             step_en,
    input  logic [OFF_W-1:0] step,
    output logic [OFF_W-1:0] sp,
    output logic [OFF_W-1:0] ss
);
    // Pointer: reset, load, or move by the step amount (mod 2^OFF_W).
    always_ff @(posedge clk) begin
        if (!rst_n)                  sp <= RST_SP;
        else if (wr_ok && !wr_sel)   sp <= wr_data;
        else if (step_en)            sp <= sp + step;
    end

    // Segment: reset or load only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ss <= RST_SS;
        else if (wr_ok && wr_sel)    ss <= wr_data;
    end

    // R9
    seg_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && wr_sel) |=> $stable(ss));
endmodule

// File: rtl/stk_seq.sv
// Sequences one push or pop as two byte accesses plus a completion cycle.
// Assumes: memory read data is valid in the same cycle as the address.
module stk_seq
    import seg_stack_pkg::*;
#(
    parameter int  OFF_W  = 16,
    parameter int  BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] mem_rdata,
    output stk_state_t        state,
    output logic              busy,
    output logic              done,
    output logic              wr_ok,
    output logic              mem_en,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [OFF_W-1:0]  off_delta,
    output logic              step_en,
    output logic [OFF_W-1:0]  step,
    output logic [WORD_W-1:0] pop_data
);
    localparam logic [OFF_W-1:0] MINUS2 = ~OFF_W'(1);
    localparam logic [OFF_W-1:0] MINUS1 = '1;
    localparam logic [OFF_W-1:0] PLUS1  = OFF_W'(1);
    localparam logic [OFF_W-1:0] PLUS2  = OFF_W'(2);

    stk_state_t        nxt;
    logic [WORD_W-1:0] data_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Next-state choice; a load in idle blocks request acceptance.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!reg_we) begin
                    if (push_req)      nxt = ST_PUSH_LO;
                    else if (pop_req)  nxt = ST_POP_LO;
                end
            end
            ST_PUSH_LO: nxt = ST_PUSH_HI;
            ST_PUSH_HI: nxt = ST_DONE;
            ST_POP_LO:  nxt = ST_POP_HI;
            ST_POP_HI:  nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture the push word when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  data_q <= '0;
        else if (state == ST_IDLE && nxt == ST_PUSH_LO) data_q <= push_data;
    end

    // Capture the read bytes at the end of each pop access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (state == ST_POP_LO) lo_q <= mem_rdata;
            if (state == ST_POP_HI) hi_q <= mem_rdata;
        end
    end

    // Memory port controls and the offset used for each access.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = data_q[BYTE_W-1:0];
        off_delta = '0;
        unique case (state)
            ST_PUSH_LO: begin
                mem_en = 1'b1; mem_we = 1'b1;
                off_delta = MINUS2;
            end
            ST_PUSH_HI: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_wdata = data_q[WORD_W-1:BYTE_W];
                off_delta = MINUS1;
            end
            ST_POP_LO: begin
                mem_en = 1'b1;
            end
            ST_POP_HI: begin
                mem_en = 1'b1;
                off_delta = PLUS1;
            end
            default: ;
        endcase
    end

    // Pointer step at the last access; status flags.
    always_comb begin
        step_en  = (state == ST_PUSH_HI) || (state == ST_POP_HI);
        step     = (state == ST_PUSH_HI) ? MINUS2 : PLUS2;
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        wr_ok    = reg_we && (state == ST_IDLE);
        pop_data = {hi_q, lo_q};
    end

    // R6
    accept_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_req && !reg_we) |=> (mem_en && mem_we));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R5
    pop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !push_req && pop_req && !reg_we) |=> (mem_en && !mem_we) ##1 (mem_en && !mem_we));
endmodule

// File: rtl/seg_stack_unit.sv
// Top of the segmented word stack unit. Ties the sequencer, the registers
// and two address generators together.
// Assumes: a combinational-read byte memory on the mem_* port.
module seg_stack_unit
    import seg_stack_pkg::*;
#(
    parameter int               OFF_W     = 16,
    parameter int               SEG_SHIFT = 4,
    parameter int               BYTE_W    = 8,
    parameter logic [OFF_W-1:0] RST_SP    = 16'hFFFE,
    parameter logic [OFF_W-1:0] RST_SS    = 16'h0000,
    localparam int              ADDR_W    = OFF_W + SEG_SHIFT,
    localparam int              WORD_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [OFF_W-1:0]  reg_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] pop_data,
    output logic [OFF_W-1:0]  sp_out,
    output logic [OFF_W-1:0]  ss_out,
    output logic [ADDR_W-1:0] tos_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    stk_state_t       state;
    logic             wr_ok;
    logic             step_en;
    logic [OFF_W-1:0] step;
    logic [OFF_W-1:0] off_delta;
    logic [OFF_W-1:0] acc_off;

    stk_seq #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .reg_we(reg_we), .mem_rdata(mem_rdata),
        .state(state), .busy(busy), .done(done), .wr_ok(wr_ok),
        .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .off_delta(off_delta), .step_en(step_en), .step(step),
        .pop_data(pop_data)
    );

    stk_ptr_regs #(.OFF_W(OFF_W), .RST_SP(RST_SP), .RST_SS(RST_SS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ok(wr_ok), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .step_en(step_en), .step(step),
        .sp(sp_out), .ss(ss_out)
    );

    // Offset of the current byte access, wrapping inside the segment.
    always_comb acc_off = sp_out + off_delta;

    stk_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_acc_addr (
        .seg(ss_out), .off(acc_off), .phys(mem_addr)
    );

    stk_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_tos_addr (
        .seg(ss_out), .off(sp_out), .phys(tos_addr)
    );

    // R4
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |=> (sp_out == $past(sp_out) - OFF_W'(2)));
    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_HI) |=> (sp_out == $past(sp_out) + OFF_W'(2)));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ss_out));
endmodule

// File: tb/sim_seg_stack_unit.sv
module sim_seg_stack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pop_req = 1'b0;
    logic [15:0] push_data = '0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] pop_data, sp_out, ss_out;
    logic [19:0] tos_addr, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [15:0] m_ss, m_sp;

    always #4 clk = ~clk;

    seg_stack_unit #(.RST_SP(16'h0008), .RST_SS(16'h0105)) u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .done(done), .pop_data(pop_data),
        .sp_out(sp_out), .ss_out(ss_out), .tos_addr(tos_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] bmem [0:4095];
    initial for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    always @(posedge clk) if (mem_en && mem_we) bmem[mem_addr[11:0]] <= mem_wdata;
    assign mem_rdata = bmem[mem_addr[11:0]];

    typedef struct packed {
        logic        is_push;
        logic [15:0] ss;
        logic [15:0] sp;
        logic [15:0] data;
        logic [19:0] exp_lo;
        logic [15:0] exp_sp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 16'h0105, 16'h0008, 16'h1234, 20'h01056, 16'h0006},
        '{1'b0, 16'h0105, 16'h0006, 16'h1234, 20'h01056, 16'h0008},
        '{1'b1, 16'h2000, 16'h0100, 16'hABCD, 20'h200FE, 16'h00FE},
        '{1'b0, 16'h2000, 16'h00FE, 16'hABCD, 20'h200FE, 16'h0100},
        '{1'b1, 16'h0000, 16'h0000, 16'h5A5A, 20'h0FFFE, 16'hFFFE},
        '{1'b0, 16'h0000, 16'hFFFE, 16'h5A5A, 20'h0FFFE, 16'h0000},
        '{1'b1, 16'hFFFF, 16'h0012, 16'hC3E1, 20'h00000, 16'h0010},
        '{1'b0, 16'hFFFF, 16'h0010, 16'hC3E1, 20'h00000, 16'h0012},
        '{1'b1, 16'h0105, 16'h0001, 16'h7788, 20'h1104F, 16'hFFFF},
        '{1'b0, 16'h0105, 16'hFFFF, 16'h7788, 20'h1104F, 16'h0001}
    };

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic sel, input logic [15:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        tick();
        reg_we = 1'b0;
        if (sel) m_ss = val; else m_sp = val;
    endtask

    // Runs one request and checks each cycle of it.
    task automatic run_op(input logic is_push, input logic [15:0] data, input logic [15:0] exp_pop);
        logic [15:0] dlo, dhi;
        dlo = is_push ? 16'hFFFE : 16'h0000;
        dhi = is_push ? 16'hFFFF : 16'h0001;
        push_req = is_push; pop_req = !is_push; push_data = data;
        tick();
        push_req = 1'b0; pop_req = 1'b0;
        chk("R6 busy first access", {31'd0, busy}, 32'd1);
        chk(is_push ? "R3 lo addr" : "R5 lo addr", {12'd0, mem_addr}, {12'd0, phys(m_ss, m_sp + dlo)});
        chk(is_push ? "R3 lo we" : "R5 lo we", {30'd0, mem_en, mem_we}, {30'd0, 1'b1, is_push});
        if (is_push) chk("R3 lo byte", {24'd0, mem_wdata}, {24'd0, data[7:0]});
        tick();
        chk(is_push ? "R3 hi addr" : "R5 hi addr", {12'd0, mem_addr}, {12'd0, phys(m_ss, m_sp + dhi)});
        chk(is_push ? "R3 hi we" : "R5 hi we", {30'd0, mem_en, mem_we}, {30'd0, 1'b1, is_push});
        if (is_push) chk("R3 hi byte", {24'd0, mem_wdata}, {24'd0, data[15:8]});
        tick();
        m_sp = is_push ? m_sp - 16'd2 : m_sp + 16'd2;
        chk("R6 done pulse", {30'd0, done, busy}, 32'd3);
        chk(is_push ? "R4 sp after push" : "R5 sp after pop", {16'd0, sp_out}, {16'd0, m_sp});
        if (!is_push) chk("R5 pop data", {16'd0, pop_data}, {16'd0, exp_pop});
        tick();
        chk("R6 idle after done", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ss = 16'h0105; m_sp = 16'h0008;
        tick(); tick();
        // R1 reset values
        chk("R1 sp", {16'd0, sp_out}, 32'h0008);
        chk("R1 ss", {16'd0, ss_out}, 32'h0105);
        chk("R1 flags", {29'd0, busy, done, mem_en}, 32'd0);
        rst_n = 1'b1;
        tick();
        // R2 top of stack address
        chk("R2 tos", {12'd0, tos_addr}, 32'h01058);

        // Vector walk (R3, R4, R5, R10)
        for (int k = 0; k < 10; k++) begin
            load(1'b1, VECS[k].ss);
            load(1'b0, VECS[k].sp);
            chk("R2 tos vec", {12'd0, tos_addr}, {12'd0, phys(VECS[k].ss, VECS[k].sp)});
            chk("R10 first access", {12'd0, phys(m_ss, m_sp + (VECS[k].is_push ? 16'hFFFE : 16'h0))},
                {12'd0, VECS[k].exp_lo});
            run_op(VECS[k].is_push, VECS[k].data, VECS[k].data);
            chk("R10 vec sp", {16'd0, sp_out}, {16'd0, VECS[k].exp_sp});
        end
        // R10 highest address of segment 0105h
        load(1'b0, 16'hFFFF);
        chk("R10 top of segment", {12'd0, tos_addr}, 32'h1104F);

        // R7 requests held high while busy
        load(1'b1, 16'h0300);
        load(1'b0, 16'h0040);
        push_req = 1'b1; push_data = 16'h4E21;
        tick();
        push_data = 16'h9999; pop_req = 1'b1;
        tick(); tick(); tick();
        chk("R7 idle after one op", {31'd0, busy}, 32'd0);
        push_req = 1'b0; pop_req = 1'b0;
        chk("R7 single step", {16'd0, sp_out}, 32'h003E);
        m_sp = 16'h003E;
        run_op(1'b0, 16'h0, 16'h4E21);

        // R8 both requests: push wins
        push_req = 1'b1; pop_req = 1'b1; push_data = 16'h0F0F;
        tick();
        push_req = 1'b0; pop_req = 1'b0;
        chk("R8 push chosen", {30'd0, mem_en, mem_we}, 32'd3);
        tick(); tick(); tick();
        chk("R8 sp", {16'd0, sp_out}, 32'h003E);
        m_sp = 16'h003E;

        // R9 load ignored while busy
        pop_req = 1'b1;
        tick();
        pop_req = 1'b0;
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 16'hAAAA;
        tick(); tick();
        reg_sel = 1'b0;
        tick();
        reg_we = 1'b0;
        chk("R9 ss kept", {16'd0, ss_out}, 32'h0300);
        chk("R9 sp kept", {16'd0, sp_out}, 32'h0040);
        m_sp = 16'h0040;
        // R9 load in idle blocks same-cycle request
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0222; push_req = 1'b1;
        tick();
        reg_we = 1'b0; push_req = 1'b0;
        chk("R9 request dropped", {31'd0, busy}, 32'd0);
        chk("R9 sp loaded", {16'd0, sp_out}, 32'h0222);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule